// File: doc/BRIEF.md
# Prioritized Interrupt Acceptance Controller

This block keeps the interrupt state of one processor core. Vectors arrive on an accept strobe and are recorded in a pending bitmap. When the core asks for work, the block finds the highest-numbered pending vector. It hands that vector over only if its priority class is above the current processor priority. A handed-over vector moves from pending to in-service, and an end-of-interrupt write later retires it.

The processor priority is formed from a software-written task priority and the highest vector now in service. It can be read at any time, as can any 32-bit word of either bitmap, selected by a word index. A software-enable bit gates all handing over of vectors. The block leaves reset with that bit clear, so software must set it before any vector is delivered.

Top module: `irq_accept_ctrl`

## Requirements
- R1: After reset both bitmaps are all zero, the task priority is 0, the processor priority reads 0, delivery is disabled and `dlv_valid` is 0.
- R2: An accept of vector v sets bit v mod 32 of bitmap word v/32, visible on the word read ports the cycle after the strobe; accepting a vector that is already pending leaves the bitmap unchanged.
- R3: The processor priority equals the task priority when the task class (bits 7:4) is at least the class of the highest in-service vector, and otherwise equals that vector; with nothing in service the in-service value is 0.
- R4: A delivery request with delivery enabled hands over the highest pending vector when its class is strictly above the processor priority class; `dlv_valid` and `dlv_vec` show it on the cycle after the request, and in that same step its pending bit clears and its in-service bit sets.
- R5: Only the highest pending vector is considered; if it is not eligible nothing is delivered (`dlv_valid` 0) and both bitmaps keep their contents.
- R6: An EOI write clears only the highest set in-service bit, and has no effect when no in-service bit is set.
- R7: While bit 8 of the enable register is 0, no vector is delivered and pending bits stay set; that register resets to 0xFF, so the block starts disabled.
- R8: A task priority write keeps only bits 7:0 of the written data.
- R9: A vector accepted in the same cycle as a delivery request is not eligible for that request, only for later ones.
- R10: `dlv_valid` is 1 only on the cycle after a delivery request, and `dlv_vec` is 0 whenever `dlv_valid` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| acc_valid | input | 1 | Accept strobe for `acc_vec` |
| acc_vec | input | 8 | Vector being accepted |
| dlv_req | input | 1 | Delivery request from the core |
| dlv_valid | output | 1 | A vector was delivered for the previous request |
| dlv_vec | output | 8 | Delivered vector, 0 when none |
| tpr_we | input | 1 | Task priority write strobe |
| tpr_wdata | input | 32 | Task priority write data |
| svr_we | input | 1 | Enable register write strobe |
| svr_wdata | input | 32 | Enable register write data (bit 8 = enable) |
| eoi_we | input | 1 | End-of-interrupt write strobe |
| ppr_out | output | 8 | Current processor priority |
| word_sel | input | 3 | Bitmap word index for the read ports |
| pend_word | output | 32 | Selected pending bitmap word |
| insvc_word | output | 32 | Selected in-service bitmap word |

## Verification
A delivery result appears on `dlv_valid`/`dlv_vec` at the same clock edge that samples the request. The monitor therefore records the request level at each rising edge and compares a short delay later against the next expected item the driver queued. Accepts, register writes and EOI change state at the edge after they are driven. The processor priority and the bitmap words are read combinationally from that state, so the checks read them on the falling edge that follows. Same-cycle accept and request, a class equal to the task priority, and EOI with nothing in service are each placed so that a wrong result shows up in one of these samples.

// File: rtl/irq_acc_pkg.sv
package irq_acc_pkg;
  localparam int DEF_VEC_W  = 8;
  localparam int DEF_WORD_W = 32;
  localparam int DEF_CLS_W  = 4;
  localparam int DEF_REG_W  = 32;
  localparam int DEF_EN_BIT = 8;
endpackage

// File: rtl/irq_top_bit.sv
// Highest-set-bit finder, split into equal segments searched in parallel.
module irq_top_bit #(
  parameter int N   = 256,
  parameter int SEG = 32
) (
  input  logic [N-1:0]         vec,
  output logic                 found,
  output logic [$clog2(N)-1:0] idx
);
  localparam int NSEG = N / SEG;
  localparam int IW   = $clog2(N);
  localparam int SW   = $clog2(SEG);

  logic [NSEG-1:0] seg_any;
  logic [SW-1:0]   seg_idx [NSEG];

  for (genvar g = 0; g < NSEG; g++) begin : g_seg
    logic [SW-1:0] local_idx;
    always_comb begin
      local_idx = '0;
      for (int i = 0; i < SEG; i++)
        if (vec[g*SEG + i]) local_idx = SW'(i);
    end
    assign seg_any[g] = |vec[g*SEG +: SEG];
    assign seg_idx[g] = local_idx;
  end

  always_comb begin
    found = |seg_any;
    idx   = '0;
    for (int s = 0; s < NSEG; s++)
      if (seg_any[s]) idx = IW'(s * SEG + int'(seg_idx[s]));
  end
endmodule

// File: rtl/irq_ppr_calc.sv
// Processor priority: task priority unless the in-service class exceeds it.
module irq_ppr_calc #(
  parameter int VEC_W = 8,
  parameter int CLS_W = 4
) (
  input  logic [VEC_W-1:0] tpr,
  input  logic             isr_found,
  input  logic [VEC_W-1:0] isr_top,
  output logic [VEC_W-1:0] ppr
);
  logic [VEC_W-1:0] isr_val;
  assign isr_val = isr_found ? isr_top : '0;
  assign ppr = (tpr[VEC_W-1 -: CLS_W] >= isr_val[VEC_W-1 -: CLS_W]) ? tpr : isr_val;
endmodule

// File: rtl/irq_accept_ctrl.sv
module irq_accept_ctrl
  import irq_acc_pkg::*;
#(
  parameter int VEC_W  = DEF_VEC_W,
  parameter int WORD_W = DEF_WORD_W,
  parameter int CLS_W  = DEF_CLS_W,
  parameter int REG_W  = DEF_REG_W,
  parameter int EN_BIT = DEF_EN_BIT
) (
  input  logic                                         clk,
  input  logic                                         rst,
  input  logic                                         acc_valid,
  input  logic [VEC_W-1:0]                             acc_vec,
  input  logic                                         dlv_req,
  output logic                                         dlv_valid,
  output logic [VEC_W-1:0]                             dlv_vec,
  input  logic                                         tpr_we,
  input  logic [REG_W-1:0]                             tpr_wdata,
  input  logic                                         svr_we,
  input  logic [REG_W-1:0]                             svr_wdata,
  input  logic                                         eoi_we,
  output logic [VEC_W-1:0]                             ppr_out,
  input  logic [$clog2((1 << VEC_W) / WORD_W)-1:0]     word_sel,
  output logic [WORD_W-1:0]                            pend_word,
  output logic [WORD_W-1:0]                            insvc_word
);
  localparam int NUM_VEC = 1 << VEC_W;

  logic [NUM_VEC-1:0] pend_q, isr_q;
  logic [NUM_VEC-1:0] pend_d, isr_d;
  logic [NUM_VEC-1:0] acc_mask, grant_mask, eoi_mask;
  logic [VEC_W-1:0]   tpr_q;
  logic               en_q;
  logic               p_found, i_found, grant;
  logic [VEC_W-1:0]   p_top, i_top, ppr;

  irq_top_bit #(.N(NUM_VEC), .SEG(WORD_W)) u_pend_enc (
    .vec(pend_q), .found(p_found), .idx(p_top)
  );

  irq_top_bit #(.N(NUM_VEC), .SEG(WORD_W)) u_isr_enc (
    .vec(isr_q), .found(i_found), .idx(i_top)
  );

  irq_ppr_calc #(.VEC_W(VEC_W), .CLS_W(CLS_W)) u_ppr (
    .tpr(tpr_q), .isr_found(i_found), .isr_top(i_top), .ppr(ppr)
  );

  // Eligibility uses registered pending state only: same-cycle accepts wait.
  assign grant = dlv_req && en_q && p_found &&
                 (p_top[VEC_W-1 -: CLS_W] > ppr[VEC_W-1 -: CLS_W]);

  always_comb begin
    acc_mask   = '0;
    grant_mask = '0;
    eoi_mask   = '0;
    if (acc_valid)         acc_mask[acc_vec] = 1'b1;
    if (grant)             grant_mask[p_top] = 1'b1;
    if (eoi_we && i_found) eoi_mask[i_top]   = 1'b1;
    pend_d = (pend_q | acc_mask) & ~grant_mask;
    isr_d  = (isr_q & ~eoi_mask) | grant_mask;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pend_q    <= '0;
      isr_q     <= '0;
      tpr_q     <= '0;
      en_q      <= 1'b0;
      dlv_valid <= 1'b0;
      dlv_vec   <= '0;
    end else begin
      pend_q    <= pend_d;
      isr_q     <= isr_d;
      if (tpr_we) tpr_q <= tpr_wdata[VEC_W-1:0];
      if (svr_we) en_q  <= svr_wdata[EN_BIT];
      dlv_valid <= grant;
      dlv_vec   <= grant ? p_top : '0;
    end
  end

  assign ppr_out    = ppr;
  assign pend_word  = pend_q[word_sel*WORD_W +: WORD_W];
  assign insvc_word = isr_q[word_sel*WORD_W +: WORD_W];
endmodule

// File: rtl/irq_accept_chk.sv
module irq_accept_chk #(
  parameter int VEC_W = 8,
  parameter int CLS_W = 4,
  parameter int REG_W = 32
) (
  input logic                    clk,
  input logic                    rst,
  input logic                    dlv_req,
  input logic                    dlv_valid,
  input logic [VEC_W-1:0]        dlv_vec,
  input logic [VEC_W-1:0]        ppr_out,
  input logic                    tpr_we,
  input logic [REG_W-1:0]        tpr_wdata,
  input logic [VEC_W-1:0]        tpr_q,
  input logic                    en_q,
  input logic [(1<<VEC_W)-1:0]   pend_q,
  input logic [(1<<VEC_W)-1:0]   isr_q
);
  logic [CLS_W-1:0] ppr_cls;
  assign ppr_cls = ppr_out[VEC_W-1 -: CLS_W];

  // R10: a result only follows a request, and carries 0 when empty
  assert_valid_after_req_R10: assert property (@(posedge clk) disable iff (rst)
    dlv_valid |-> $past(dlv_req));
  assert_vec_zero_idle_R10: assert property (@(posedge clk) disable iff (rst)
    !dlv_valid |-> dlv_vec == '0);

  // R7: disabled in the request cycle means nothing delivered
  assert_no_dlv_disabled_R7: assert property (@(posedge clk) disable iff (rst)
    !$past(en_q) |-> !dlv_valid);

  // R4: class strictly above the priority at request time
  assert_class_above_R4: assert property (@(posedge clk) disable iff (rst)
    dlv_valid |-> dlv_vec[VEC_W-1 -: CLS_W] > $past(ppr_cls));

  // R4: delivered vector has moved to in-service
  assert_moved_insvc_R4: assert property (@(posedge clk) disable iff (rst)
    dlv_valid |-> (isr_q[dlv_vec] && !pend_q[dlv_vec]));

  // R8: only the low byte of a write lands in the task priority
  assert_tpr_low_byte_R8: assert property (@(posedge clk) disable iff (rst)
    tpr_we |=> tpr_q == $past(tpr_wdata[VEC_W-1:0]));

  // R3: processor priority never below the task priority
  assert_ppr_floor_R3: assert property (@(posedge clk) disable iff (rst)
    ppr_out >= tpr_q);
endmodule

bind irq_accept_ctrl irq_accept_chk #(.VEC_W(VEC_W), .CLS_W(CLS_W), .REG_W(REG_W)) u_chk (
  .clk(clk), .rst(rst), .dlv_req(dlv_req), .dlv_valid(dlv_valid), .dlv_vec(dlv_vec),
  .ppr_out(ppr_out), .tpr_we(tpr_we), .tpr_wdata(tpr_wdata), .tpr_q(tpr_q),
  .en_q(en_q), .pend_q(pend_q), .isr_q(isr_q)
);

// File: tb/tb_irq_accept_ctrl.sv
module tb_irq_accept_ctrl;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        acc_valid = 1'b0;
  logic [7:0]  acc_vec = '0;
  logic        dlv_req = 1'b0;
  logic        dlv_valid;
  logic [7:0]  dlv_vec;
  logic        tpr_we = 1'b0;
  logic [31:0] tpr_wdata = '0;
  logic        svr_we = 1'b0;
  logic [31:0] svr_wdata = '0;
  logic        eoi_we = 1'b0;
  logic [7:0]  ppr_out;
  logic [2:0]  word_sel = '0;
  logic [31:0] pend_word, insvc_word;

  int checks = 0;
  int errors = 0;
  logic [8:0] exp_q [$];

  always #4 clk = ~clk;

  irq_accept_ctrl dut (
    .clk(clk), .rst(rst), .acc_valid(acc_valid), .acc_vec(acc_vec),
    .dlv_req(dlv_req), .dlv_valid(dlv_valid), .dlv_vec(dlv_vec),
    .tpr_we(tpr_we), .tpr_wdata(tpr_wdata), .svr_we(svr_we), .svr_wdata(svr_wdata),
    .eoi_we(eoi_we), .ppr_out(ppr_out), .word_sel(word_sel),
    .pend_word(pend_word), .insvc_word(insvc_word)
  );

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic accept(input logic [7:0] v);
    @(negedge clk); acc_valid = 1'b1; acc_vec = v;
    @(negedge clk); acc_valid = 1'b0;
  endtask

  task automatic request(input bit ev, input logic [7:0] evec);
    @(negedge clk); dlv_req = 1'b1; exp_q.push_back({ev, evec});
    @(negedge clk); dlv_req = 1'b0;
  endtask

  task automatic accept_and_request(input logic [7:0] v, input bit ev, input logic [7:0] evec);
    @(negedge clk); acc_valid = 1'b1; acc_vec = v; dlv_req = 1'b1; exp_q.push_back({ev, evec});
    @(negedge clk); acc_valid = 1'b0; dlv_req = 1'b0;
  endtask

  task automatic write_tpr(input logic [31:0] d);
    @(negedge clk); tpr_we = 1'b1; tpr_wdata = d;
    @(negedge clk); tpr_we = 1'b0;
  endtask

  task automatic write_svr(input logic [31:0] d);
    @(negedge clk); svr_we = 1'b1; svr_wdata = d;
    @(negedge clk); svr_we = 1'b0;
  endtask

  task automatic eoi();
    @(negedge clk); eoi_we = 1'b1;
    @(negedge clk); eoi_we = 1'b0;
  endtask

  task automatic chk_pend(input logic [2:0] w, input logic [31:0] exp, input string tag);
    word_sel = w; #1;
    chk(pend_word == exp, tag, pend_word, exp);
  endtask

  task automatic chk_isr(input logic [2:0] w, input logic [31:0] exp, input string tag);
    word_sel = w; #1;
    chk(insvc_word == exp, tag, insvc_word, exp);
  endtask

  task automatic chk_ppr(input logic [7:0] exp, input string tag);
    chk(ppr_out == exp, tag, {24'h0, ppr_out}, {24'h0, exp});
  endtask

  // Monitor: result is due at the edge that samples the request
  initial begin
    forever begin
      logic r;
      @(posedge clk);
      r = dlv_req;
      #2;
      if (r) begin
        if (exp_q.size() == 0) begin
          chk(1'b0, "R10 unexpected request", {23'h0, dlv_valid, dlv_vec}, 32'h0);
        end else begin
          logic [8:0] e;
          e = exp_q.pop_front();
          chk({dlv_valid, dlv_vec} == e, "R4/R5 delivery result",
              {23'h0, dlv_valid, dlv_vec}, {23'h0, e});
        end
      end else if (!rst) begin
        chk(dlv_valid == 1'b0 && dlv_vec == 8'h0, "R10 idle output",
            {23'h0, dlv_valid, dlv_vec}, 32'h0);
      end
    end
  end

  initial begin
    #(8 * 200000);
    errors++;
    checks++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1: reset state
    chk_ppr(8'h00, "R1 ppr after reset");
    for (int w = 0; w < 8; w++) begin
      chk_pend(3'(w), 32'h0, "R1 pending clear");
      chk_isr(3'(w), 32'h0, "R1 in-service clear");
    end
    // R7: starts disabled
    accept(8'h45);
    chk_pend(3'd2, 32'h0000_0020, "R2 accept 0x45 word2 bit5");
    request(1'b0, 8'h00);
    chk_pend(3'd2, 32'h0000_0020, "R7 pending kept while disabled");
    write_svr(32'h0000_01FF);
    accept(8'h45);
    chk_pend(3'd2, 32'h0000_0020, "R2 duplicate accept merges");
    accept(8'h30);
    accept(8'h91);
    // R4: highest vector 0x91 delivered
    request(1'b1, 8'h91);
    chk_pend(3'd4, 32'h0, "R4 pending cleared on delivery");
    chk_isr(3'd4, 32'h0002_0000, "R4 in-service set on delivery");
    chk_ppr(8'h91, "R3 ppr from in-service");
    // R5: top pending 0x45 class 4 not above 9
    request(1'b0, 8'h00);
    chk_pend(3'd2, 32'h0000_0020, "R5 0x45 still pending");
    chk_pend(3'd1, 32'h0001_0000, "R5 0x30 still pending");
    // R8: only low byte kept
    write_tpr(32'hABCD_0E25);
    chk_ppr(8'h91, "R3 in-service class dominates");
    eoi();
    chk_isr(3'd4, 32'h0, "R6 EOI clears 0x91");
    chk_ppr(8'h25, "R8 tpr low byte");
    request(1'b1, 8'h45);
    chk_ppr(8'h45, "R3 ppr 0x45");
    request(1'b0, 8'h00); // R5: 0x30 class 3 under 4
    write_tpr(32'h0000_0050);
    chk_ppr(8'h50, "R3 tpr class above in-service");
    eoi();
    chk_isr(3'd2, 32'h0, "R6 EOI clears 0x45");
    write_tpr(32'h0);
    request(1'b1, 8'h30);
    accept(8'hE0);
    request(1'b1, 8'hE0);
    eoi();
    chk_isr(3'd7, 32'h0, "R6 EOI clears highest only");
    chk_isr(3'd1, 32'h0001_0000, "R6 lower in-service kept");
    eoi();
    chk_isr(3'd1, 32'h0, "R6 EOI clears 0x30");
    eoi();
    for (int w = 0; w < 8; w++) chk_isr(3'(w), 32'h0, "R6 EOI with empty in-service");
    chk_ppr(8'h00, "R6 ppr after empty EOI");
    // R9: same-cycle accept not eligible
    accept_and_request(8'h70, 1'b0, 8'h00);
    chk_pend(3'd3, 32'h0001_0000, "R9 0x70 pending after same-cycle request");
    request(1'b1, 8'h70);
    chk_ppr(8'h70, "R3 ppr 0x70");
    write_tpr(32'h7A);
    chk_ppr(8'h7A, "R3 equal class picks tpr");
    write_tpr(32'h6F);
    chk_ppr(8'h70, "R3 lower tpr class picks in-service");
    // R7: disabling stops delivery
    write_svr(32'h0000_00FF);
    accept(8'hF3);
    request(1'b0, 8'h00);
    chk_pend(3'd7, 32'h0008_0000, "R7 pending kept after disable");
    repeat (3) @(negedge clk);
    chk(exp_q.size() == 0, "R10 all results seen", exp_q.size(), 32'h0);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule